// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in-first-out buffer for a 9-bit data stream whose producer and consumer run on unrelated clocks. Either clock may be the faster one, and a write and a read may happen in the same moment. The write side takes data, a write strobe, a load strobe for the threshold registers and a serial loading path. The read side returns data through a registered output that floats when the output enable is low. Five level indications are available: empty (or output-ready), full (or input-ready), more-than-half, near-empty and near-full.

Each pointer crosses into the other clock domain as a Gray code through a short synchronizer chain. Full, near-full and half are computed in the write domain. Empty and near-empty are computed in the read domain. A master reset clears the whole block and takes two configuration choices from pins: the output timing mode and which preset pair of thresholds applies. A partial reset clears only the stored data and the pointers. The rewind input replays the stored stream from the first word written since the last reset.

In the standard timing mode, each word is fetched by a read strobe. In fall-through mode, the next word is already waiting on the output before the strobe, and the strobe consumes it.

Top module: `dualclk_flag_fifo`

## Requirements
- R1: While `mrst_n` is low, the block clears its data and its pointers. After release, `rflag`=1, `half`=0, `aempty`=1 and `afull`=0 in standard mode. Both thresholds equal `OFS_DEF0` if `dsel` was 0 during reset, and `OFS_DEF1` if it was 1.
- R2: In standard mode (`rflag`=1 means empty), a `ren` pulse while not empty puts the oldest word on `q` at that `rclk` edge. Words leave in the order they were written.
- R3: A write while full and a read while empty (standard mode) are ignored. The stored data and the pointers stay unchanged.
- R4: The write-side count is the number of writes minus the number of reads seen through the synchronizer. In standard mode `wflag`=1 when the count equals DEPTH (2^AW). `half`=1 when the count exceeds DEPTH/2.
- R5: `aempty`=1 when the read-side level is at most the empty threshold. `afull`=1 when the write-side count is at least DEPTH minus the full threshold.
- R6: A write edge with `ld`=1 and `wen`=1 stores `din[AW-1:0]` into a threshold register instead of the FIFO. The first such load goes to the empty threshold, the next to the full threshold, and the target alternates after that.
- R7: Each write edge with `sen`=1 and `ld`=0 shifts `fwft_si` into a 2·AW-bit chain. After 2·AW shifts, the full threshold holds the first AW bits (MSB first) and the empty threshold holds the next AW bits (MSB first).
- R8: A low `prst_n` empties the FIFO and clears the pointers. It keeps both thresholds and the timing mode.
- R9: `fwft_si`=1 during master reset selects fall-through mode. In this mode `rflag`=1 means a word is waiting on `q` and `wflag`=1 means there is room. The first word written into an empty FIFO appears on `q` with no `ren`, by the third `rclk` rising edge after its write edge. A `ren` consumes the shown word and shows the next one at the same edge.
- R10: An `rt` edge rewinds the read pointer to the first word written since the last reset. Standard mode then returns that word on the next read. Fall-through mode shows it again by the second `rclk` edge after the rewind.
- R11: With `oe`=0, `q` is all high-impedance. With `oe`=1, `q` shows the output register.
- R12: In standard mode, the empty indication falls by the second `rclk` rising edge after the write edge of the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, held over several edges of both clocks |
| prst_n | input | 1 | Partial reset, active low |
| wen | input | 1 | Write strobe |
| ld | input | 1 | Threshold parallel-load strobe (used with `wen`) |
| sen | input | 1 | Serial threshold shift enable |
| fwft_si | input | 1 | Timing mode during master reset; serial threshold bit afterwards |
| dsel | input | 1 | Preset threshold pair choice, sampled during master reset |
| din | input | DW | Write data and parallel threshold value |
| ren | input | 1 | Read strobe |
| rt | input | 1 | Rewind to first stored word |
| oe | input | 1 | Output enable |
| q | output | DW | Read data, high-impedance when `oe`=0 |
| wflag | output | 1 | Full (standard) or room available (fall-through) |
| rflag | output | 1 | Empty (standard) or word waiting (fall-through) |
| half | output | 1 | More than half of the locations are in use |
| aempty | output | 1 | Level at or below the empty threshold |
| afull | output | 1 | Count at or above DEPTH minus the full threshold |

## Verification
Flags on the writer's own side (full, half, near-full) settle just after the write edge. Any flag that depends on the other domain is due two synchronizer edges plus one register edge later. In standard mode, read data is on `q` right after the strobed `rclk` edge. In fall-through mode, the first word needs three `rclk` edges and a rewound word needs two. The bench drives every input on a falling clock edge. It reads data just after the strobed edge. It checks cross-domain flags only after four falling edges of each clock. The latency cases (R9, R12) are also sampled right after the write, to confirm that the indication has not yet changed.

// File: rtl/xcf_pkg.sv
package xcf_pkg;
   typedef enum logic {
      TM_STD  = 1'b0,
      TM_FWFT = 1'b1
   } tmode_e;
endpackage

// File: rtl/xcf_sync.sv
module xcf_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xcf_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         st <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/xcf_ram.sv
module xcf_ram #(
   parameter int DW = 9,
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/xcf_wside.sv
module xcf_wside
   import xcf_pkg::*;
#(
   parameter int AW       = 4,
   parameter int OFS_DEF0 = 2,
   parameter int OFS_DEF1 = 4
) (
   input  logic          wclk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          wen,
   input  logic          ld,
   input  logic          sen,
   input  logic          mode_si,
   input  logic          dsel,
   input  logic [AW-1:0] ofs_din,
   input  logic [AW:0]   rgray_s,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic [AW-1:0] pae_off,
   output logic [AW-1:0] paf_off,
   output logic          full,
   output logic          afull,
   output logic          half,
   output tmode_e        tmode
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
   localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
   localparam logic [AW-1:0] DEF0    = AW'(OFS_DEF0);
   localparam logic [AW-1:0] DEF1    = AW'(OFS_DEF1);

   generate
      if (OFS_DEF0 >= DEPTH || OFS_DEF1 >= DEPTH || OFS_DEF0 < 0 || OFS_DEF1 < 0) begin : g_bad_def
         $error("preset thresholds must lie in 0..DEPTH-1");
      end
   endgenerate

   logic          rst;
   logic [PW-1:0] wptr, wptr_nx, wgray_nx, rbin, wcnt;
   logic          ld_sel;

   assign rst = !mrst_n || !prst_n;

   always_comb begin
      for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
   end

   assign wptr_nx  = wptr + PW'(1);
   assign wgray_nx = wptr_nx ^ (wptr_nx >> 1);
   assign wcnt     = wptr - rbin;
   assign full     = (wcnt == DEPTH_P);
   assign half     = (wcnt > HALF_P);
   assign afull    = (wcnt >= (DEPTH_P - {1'b0, paf_off}));
   assign we       = wen && !ld && !full;
   assign waddr    = wptr[AW-1:0];

   always_ff @(posedge wclk) begin
      if (rst) begin
         wptr  <= '0;
         wgray <= '0;
      end else if (we) begin
         wptr  <= wptr_nx;
         wgray <= wgray_nx;
      end
   end

   always_ff @(posedge wclk) begin
      if (!mrst_n) begin
         tmode   <= tmode_e'(mode_si);
         pae_off <= dsel ? DEF1 : DEF0;
         paf_off <= dsel ? DEF1 : DEF0;
         ld_sel  <= 1'b0;
      end else if (!prst_n) begin
         ld_sel  <= 1'b0;
      end else if (ld && wen) begin
         if (!ld_sel) pae_off <= ofs_din;
         else         paf_off <= ofs_din;
         ld_sel <= !ld_sel;
      end else if (sen && !ld) begin
         {paf_off, pae_off} <= {paf_off[AW-2:0], pae_off, mode_si};
      end
   end

   p_no_overflow_r3: assert property (@(posedge wclk) disable iff (rst)
      (full && wen) |=> $stable(wptr));

   p_load_no_write_r6: assert property (@(posedge wclk) disable iff (rst)
      ld |=> $stable(wptr));

   p_count_bound_r4: assert property (@(posedge wclk) disable iff (rst)
      wcnt <= DEPTH_P);
endmodule

// File: rtl/xcf_rside.sv
module xcf_rside
   import xcf_pkg::*;
#(
   parameter int DW = 9,
   parameter int AW = 4
) (
   input  logic          rclk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          ren,
   input  logic          rt,
   input  logic          mode_si,
   input  logic [AW:0]   wgray_s,
   input  logic [AW-1:0] pae_off,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] dq,
   output logic          rflag,
   output logic          aempty
);
   localparam int PW = AW + 1;

   tmode_e        tmode;
   logic          rst, has, take, valid, fw;
   logic [PW-1:0] rptr, rptr_nx, rgray_nx, wbin, rcnt, level;

   assign rst = !mrst_n || !prst_n;
   assign fw  = (tmode == TM_FWFT);

   always_comb begin
      for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
   end

   assign rcnt     = wbin - rptr;
   assign has      = (rcnt != '0);
   assign rptr_nx  = rptr + PW'(1);
   assign rgray_nx = rptr_nx ^ (rptr_nx >> 1);
   assign take     = has && (fw ? (!valid || ren) : ren);
   assign level    = rcnt + PW'(fw && valid);
   assign rflag    = fw ? valid : !has;
   assign aempty   = (level <= {1'b0, pae_off});
   assign raddr    = rptr[AW-1:0];

   always_ff @(posedge rclk) begin
      if (!mrst_n) tmode <= tmode_e'(mode_si);
   end

   always_ff @(posedge rclk) begin
      if (rst) begin
         rptr  <= '0;
         rgray <= '0;
         valid <= 1'b0;
         dq    <= '0;
      end else if (rt) begin
         rptr  <= '0;
         rgray <= '0;
         valid <= 1'b0;
      end else if (take) begin
         rptr  <= rptr_nx;
         rgray <= rgray_nx;
         dq    <= rdata;
         valid <= 1'b1;
      end else if (ren) begin
         valid <= 1'b0;
      end
   end

   p_no_underflow_r3: assert property (@(posedge rclk) disable iff (rst)
      (!fw && !has && ren && !rt) |=> ($stable(rptr) && $stable(dq)));

   p_std_advance_r2: assert property (@(posedge rclk) disable iff (rst)
      (!fw && has && ren && !rt) |=> (rptr == $past(rptr) + PW'(1)));

   p_rewind_r10: assert property (@(posedge rclk) disable iff (rst)
      rt |=> (rptr == '0));

   p_fwft_hold_r9: assert property (@(posedge rclk) disable iff (rst)
      (fw && valid && !ren && !rt) |=> (valid && $stable(dq)));
endmodule

// File: rtl/dualclk_flag_fifo.sv
module dualclk_flag_fifo
   import xcf_pkg::*;
#(
   parameter int DW          = 9,
   parameter int AW          = 4,
   parameter int OFS_DEF0    = 2,
   parameter int OFS_DEF1    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          wen,
   input  logic          ld,
   input  logic          sen,
   input  logic          fwft_si,
   input  logic          dsel,
   input  logic [DW-1:0] din,
   input  logic          ren,
   input  logic          rt,
   input  logic          oe,
   output logic [DW-1:0] q,
   output logic          wflag,
   output logic          rflag,
   output logic          half,
   output logic          aempty,
   output logic          afull
);
   localparam int PW = AW + 1;

   generate
      if (AW < 2 || AW > DW) begin : g_bad_aw
         $error("AW must be at least 2 and no wider than DW");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          rst_any, we, full;
   logic [AW-1:0] waddr, raddr, pae_off, paf_off;
   logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
   logic [DW-1:0] rdata, dq;
   tmode_e        wmode;

   assign rst_any = !mrst_n || !prst_n;

   xcf_wside #(.AW(AW), .OFS_DEF0(OFS_DEF0), .OFS_DEF1(OFS_DEF1)) u_wside (
      .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .wen(wen), .ld(ld),
      .sen(sen), .mode_si(fwft_si), .dsel(dsel), .ofs_din(din[AW-1:0]),
      .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
      .pae_off(pae_off), .paf_off(paf_off), .full(full), .afull(afull),
      .half(half), .tmode(wmode)
   );

   xcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rclk), .rst(rst_any), .d(wgray), .q(wgray_s)
   );

   xcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wclk), .rst(rst_any), .d(rgray), .q(rgray_s)
   );

   xcf_ram #(.DW(DW), .AW(AW)) u_ram (
      .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
      .raddr(raddr), .rdata(rdata)
   );

   xcf_rside #(.DW(DW), .AW(AW)) u_rside (
      .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .ren(ren), .rt(rt),
      .mode_si(fwft_si), .wgray_s(wgray_s), .pae_off(pae_off),
      .rdata(rdata), .raddr(raddr), .rgray(rgray), .dq(dq),
      .rflag(rflag), .aempty(aempty)
   );

   assign wflag = (wmode == TM_FWFT) ? !full : full;
   assign q     = oe ? dq : {DW{1'bz}};
endmodule

// File: tb/dualclk_flag_fifo_tb_top.sv
`timescale 1ns/100ps
module dualclk_flag_fifo_tb_top;
   localparam int DW = 9, AW = 3, DEPTH = 8, D0 = 1, D1 = 3;

   logic wclk = 1'b0, rclk = 1'b0;
   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   logic mrst_n = 1'b0, prst_n = 1'b1, wen = 1'b0, ld = 1'b0, sen = 1'b0;
   logic fwft_si = 1'b0, dsel = 1'b0, ren = 1'b0, rt = 1'b0, oe = 1'b1;
   logic [DW-1:0] din = '0;
   wire  [DW-1:0] q;
   wire  wflag, rflag, half, aempty, afull;

   dualclk_flag_fifo #(.DW(DW), .AW(AW), .OFS_DEF0(D0), .OFS_DEF1(D1)) dut_i (
      .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .wen(wen),
      .ld(ld), .sen(sen), .fwft_si(fwft_si), .dsel(dsel), .din(din),
      .ren(ren), .rt(rt), .oe(oe), .q(q), .wflag(wflag), .rflag(rflag),
      .half(half), .aempty(aempty), .afull(afull)
   );

   int n_chk = 0, n_bad = 0, lvl = 0;
   bit done = 1'b0;
   logic [DW-1:0] mdl[$];
   logic [DW-1:0] saved[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge rclk);
      repeat (4) @(negedge wclk);
   endtask

   task automatic wr(input logic [DW-1:0] d);
      @(negedge wclk);
      din = d; wen = 1'b1;
      @(negedge wclk);
      wen = 1'b0;
      if (lvl < DEPTH) begin mdl.push_back(d); lvl++; end
   endtask

   task automatic rd_std(input string tag);
      @(negedge rclk); ren = 1'b1;
      @(negedge rclk); ren = 1'b0;
      if (lvl > 0) begin chk(tag, q, mdl.pop_front()); lvl--; end
   endtask

   task automatic pulse_ren();
      @(negedge rclk); ren = 1'b1;
      @(negedge rclk); ren = 1'b0;
   endtask

   task automatic do_mrst(input logic mode, input logic ds);
      @(negedge wclk); mrst_n = 1'b0; fwft_si = mode; dsel = ds;
      repeat (4) @(negedge rclk);
      @(negedge wclk); mrst_n = 1'b1; fwft_si = 1'b0;
      lvl = 0; mdl.delete();
      settle();
   endtask

   task automatic do_prst();
      @(negedge wclk); prst_n = 1'b0;
      repeat (4) @(negedge rclk);
      @(negedge wclk); prst_n = 1'b1;
      lvl = 0; mdl.delete();
      settle();
   endtask

   // R4 R5: flags expected from fill level n and the two thresholds
   task automatic flags(input string tag, input int n, input int eo, input int fo);
      chk($sformatf("%s R4 full n=%0d", tag, n),  wflag,  32'(n == DEPTH));
      chk($sformatf("%s R4 half n=%0d", tag, n),  half,   32'(n > DEPTH / 2));
      chk($sformatf("%s R5 aempty n=%0d", tag, n), aempty, 32'(n <= eo));
      chk($sformatf("%s R5 afull n=%0d", tag, n),  afull,  32'(n >= DEPTH - fo));
      chk($sformatf("%s R2 empty n=%0d", tag, n),  rflag,  32'(n == 0));
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] prev, a;
      // R1 reset state with preset pair 0
      do_mrst(1'b0, 1'b0);
      flags("R1 reset", 0, D0, D0);

      // R4 R5 fill sweep
      for (int k = 1; k <= DEPTH; k++) begin
         wr(DW'(k * 37 + 5));
         settle();
         flags("R4 R5 fill", k, D0, D0);
      end
      // R3 write while full is dropped
      wr(9'h1AA);
      settle();
      flags("R3 overflow", DEPTH, D0, D0);
      // R2 drain order and downward sweep
      for (int k = DEPTH - 1; k >= 0; k--) begin
         rd_std("R2 order");
         settle();
         flags("R4 R5 drain", k, D0, D0);
      end
      // R3 read while empty is ignored
      prev = q;
      pulse_ren();
      chk("R3 underflow q held", q, prev);
      settle();
      flags("R3 underflow", 0, D0, D0);
      wr(9'h055);
      settle();
      rd_std("R3 after underflow");
      settle();

      // R12 empty falls by second rclk edge
      wr(9'h0F0);
      chk("R12 empty still set", rflag, 1);
      repeat (3) @(negedge rclk);
      chk("R12 empty cleared", rflag, 0);
      rd_std("R12 data");
      settle();

      // R6 parallel load: empty threshold 2, full threshold 5
      @(negedge wclk); ld = 1'b1; wen = 1'b1; din = 9'd2;
      @(negedge wclk); din = 9'd5;
      @(negedge wclk); ld = 1'b0; wen = 1'b0;
      settle();
      flags("R6 no data", 0, 2, 5);
      for (int k = 1; k <= 4; k++) begin
         wr(DW'(k + 100));
         settle();
         flags("R6 loaded", k, 2, 5);
      end

      // R8 partial reset keeps thresholds
      do_prst();
      flags("R8 cleared", 0, 2, 5);
      for (int k = 1; k <= 3; k++) begin
         wr(DW'(k + 200));
         settle();
         flags("R8 kept", k, 2, 5);
      end

      // R10 rewind in standard mode
      do_prst();
      for (int k = 0; k < 5; k++) wr(DW'(9'h140 + k));
      saved = mdl;
      settle();
      for (int k = 0; k < 3; k++) rd_std("R10 before rewind");
      @(negedge rclk); rt = 1'b1;
      @(negedge rclk); rt = 1'b0;
      mdl = saved; lvl = 5;
      settle();
      flags("R10 level", 5, 2, 5);
      rd_std("R10 rewind first word");

      // R1 preset pair 1
      do_mrst(1'b0, 1'b1);
      flags("R1 preset B", 0, D1, D1);
      for (int k = 1; k <= 5; k++) begin
         wr(DW'(k + 50));
         settle();
         flags("R1 preset B", k, D1, D1);
      end

      // R7 serial load: full=6 then empty=1, MSB first
      do_mrst(1'b0, 1'b0);
      for (int b = 0; b < 6; b++) begin
         @(negedge wclk); sen = 1'b1; fwft_si = (6'b110001 >> (5 - b)) & 1'b1;
      end
      @(negedge wclk); sen = 1'b0; fwft_si = 1'b0;
      settle();
      flags("R7 serial", 0, 1, 6);
      for (int k = 1; k <= 3; k++) begin
         wr(DW'(k + 300));
         settle();
         flags("R7 serial", k, 1, 6);
      end

      // R9 fall-through mode
      do_mrst(1'b1, 1'b0);
      chk("R9 ready low after reset", rflag, 0);
      chk("R9 room high after reset", wflag, 1);
      wr(9'h1C3);
      repeat (4) @(negedge rclk);
      chk("R9 fall through data", q, 9'h1C3);
      chk("R9 ready", rflag, 1);
      for (int k = 0; k < 3; k++) wr(DW'(9'h0A0 + k));
      settle();
      for (int k = 0; k < 4; k++) begin
         chk("R9 order", q, mdl.pop_front());
         pulse_ren();
      end
      lvl = 0;
      settle();
      chk("R9 ready after drain", rflag, 0);

      // R8 mode kept across partial reset, then R10 in fall-through mode
      do_prst();
      a = 9'h0DE;
      wr(a);
      repeat (4) @(negedge rclk);
      chk("R8 mode kept", q, a);
      wr(9'h0AD);
      wr(9'h0BE);
      settle();
      pulse_ren();
      pulse_ren();
      chk("R10 fwft third word", q, 9'h0BE);
      @(negedge rclk); rt = 1'b1;
      @(negedge rclk); rt = 1'b0;
      repeat (2) @(negedge rclk);
      chk("R10 fwft rewind", q, a);

      // R11 output enable
      oe = 1'b0;
      #1;
      chk("R11 float", 32'(q === {DW{1'bz}}), 1);
      oe = 1'b1;
      #1;
      chk("R11 drive", q, a);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule